// File: doc/BRIEF.md
# Privilege-Checked Virtual Address Segment Decoder

This block sorts a 32-bit virtual address into one of five fixed segments and, for each access, chooses one of three outcomes. The address can be sent on to a TLB for translation. It can be mapped directly to a physical address by a fixed rule. Or it can be refused with an address-error code. The choice depends on the current privilege mode, an error-level flag and the access direction.

The decoder is purely combinational and sits in front of the TLB lookup in a load/store or fetch path. The top three address bits select the segment. A per-segment privilege rule then picks the route. A directly mapped access always carries read and write permission. A refused access reports a load or store flavour of address error, so the exception logic downstream can write its cause field without decoding again.

Top module: `vseg_decode`

## Requirements
- R1: With `err_level` low, any address from 0x00000000 to 0x7FFFFFFF raises `tlb_req` in every mode and reports `seg_id` 0.
- R2: With `err_level` high, an address from 0x00000000 to 0x7FFFFFFF is mapped directly: `phys_valid` is 1 and `phys_addr` equals the address.
- R3: An address from 0x80000000 to 0x9FFFFFFF is allowed only in kernel mode. It maps directly to the address minus 0x80000000 and reports `seg_id` 1.
- R4: An address from 0xA0000000 to 0xBFFFFFFF is allowed only in kernel mode. It maps directly to the address minus 0xA0000000 and reports `seg_id` 2.
- R5: An address from 0xC0000000 to 0xDFFFFFFF raises `tlb_req` in supervisor or kernel mode and reports `seg_id` 3.
- R6: An address from 0xE0000000 to 0xFFFFFFFF raises `tlb_req` only in kernel mode and reports `seg_id` 4.
- R7: A disallowed access raises `addr_err`. `exc_code` is 5 when `is_write` is 1 and 4 when `is_write` is 0. It is 0 whenever `addr_err` is low.
- R8: `perm_rd` and `perm_wr` are both 1 exactly when `phys_valid` is 1, and both 0 otherwise.
- R9: `mode` is encoded as 2'b00 kernel, 2'b01 supervisor and 2'b10 user. The value 2'b11 behaves exactly as user.
- R10: For every input, exactly one of `phys_valid`, `tlb_req` and `addr_err` is 1. `phys_addr` is 0 whenever `phys_valid` is 0.
- R11: `err_level` has no effect on any output for addresses at or above 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vaddr | input | 32 | Virtual address of the access |
| mode | input | 2 | Privilege mode: 00 kernel, 01 supervisor, 10/11 user |
| err_level | input | 1 | Error-level flag; makes the low half of the space an identity map |
| is_write | input | 1 | 1 for a store, 0 for a load |
| seg_id | output | 3 | Segment index 0..4 |
| phys_valid | output | 1 | Direct physical mapping is valid |
| phys_addr | output | 32 | Direct physical address (0 when not valid) |
| perm_rd | output | 1 | Read permission of the direct mapping |
| perm_wr | output | 1 | Write permission of the direct mapping |
| tlb_req | output | 1 | Address must be translated by the TLB |
| addr_err | output | 1 | Access refused |
| exc_code | output | 5 | 0 none, 4 address error on load, 5 address error on store |

## Verification
The immediate assertions rely on all inputs being settled 0/1 values that are held steady while the outputs are evaluated. An X on `mode` or `vaddr` would break the route one-hot property. The bench changes inputs only on the falling clock edge and compares the outputs at the next rising edge, so no check sees values mid-update. The sweep covers every segment boundary and interior, the low and high end of each segment, all four mode codes, both error-level values and both directions.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

    typedef enum logic [2:0] {
        SEG_USER  = 3'd0,
        SEG_KDIR0 = 3'd1,
        SEG_KDIR1 = 3'd2,
        SEG_SMAP  = 3'd3,
        SEG_KMAP  = 3'd4
    } seg_e;

    typedef enum logic [1:0] {
        ROUTE_DIRECT = 2'd0,
        ROUTE_TLB    = 2'd1,
        ROUTE_FAULT  = 2'd2
    } route_e;

    localparam logic [1:0] PRIV_KERN = 2'b00;
    localparam logic [1:0] PRIV_SUPV = 2'b01;

    localparam logic [4:0] EXC_NONE       = 5'd0;
    localparam logic [4:0] EXC_ADDR_LOAD  = 5'd4;
    localparam logic [4:0] EXC_ADDR_STORE = 5'd5;

endpackage

// File: rtl/vseg_classify.sv
module vseg_classify
    import vseg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] vaddr,
    output seg_e              seg
);
    localparam int TOP_LSB = ADDR_W - 3;

    logic [2:0] top_d;

    always_comb begin
        top_d = vaddr[ADDR_W-1:TOP_LSB];
        unique case (top_d)
            3'b100:  seg = SEG_KDIR0;
            3'b101:  seg = SEG_KDIR1;
            3'b110:  seg = SEG_SMAP;
            3'b111:  seg = SEG_KMAP;
            default: seg = SEG_USER;
        endcase
    end

endmodule

// File: rtl/vseg_grant.sv
module vseg_grant
    import vseg_pkg::*;
(
    input  seg_e       seg,
    input  logic [1:0] mode,
    input  logic       err_level,
    output route_e     route
);
    typedef struct packed {
        logic   kern;
        logic   supv;
        route_e route;
    } grant_t;

    grant_t grant_d;

    always_comb begin
        grant_d      = '0;
        grant_d.kern = (mode == PRIV_KERN);
        grant_d.supv = (mode == PRIV_SUPV);
        unique case (seg)
            SEG_USER:  grant_d.route = err_level ? ROUTE_DIRECT : ROUTE_TLB;
            SEG_KDIR0,
            SEG_KDIR1: grant_d.route = grant_d.kern ? ROUTE_DIRECT : ROUTE_FAULT;
            SEG_SMAP:  grant_d.route = (grant_d.kern || grant_d.supv) ? ROUTE_TLB : ROUTE_FAULT;
            default:   grant_d.route = grant_d.kern ? ROUTE_TLB : ROUTE_FAULT;
        endcase
        route = grant_d.route;
    end

endmodule

// File: rtl/vseg_direct.sv
module vseg_direct
    import vseg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  seg_e              seg,
    output logic [ADDR_W-1:0] paddr
);
    localparam int WIN_W = ADDR_W - 3;

    always_comb begin
        unique case (seg)
            SEG_USER:  paddr = vaddr;
            SEG_KDIR0,
            SEG_KDIR1: paddr = {3'b000, vaddr[WIN_W-1:0]};
            default:   paddr = '0;
        endcase
    end

endmodule

// File: rtl/vseg_decode.sv
module vseg_decode
    import vseg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [1:0]        mode,
    input  logic              err_level,
    input  logic              is_write,
    output logic [2:0]        seg_id,
    output logic              phys_valid,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              perm_rd,
    output logic              perm_wr,
    output logic              tlb_req,
    output logic              addr_err,
    output logic [4:0]        exc_code
);
    localparam int WIN_W = ADDR_W - 3;

    typedef struct packed {
        logic [2:0]        seg_id;
        logic              phys_valid;
        logic [ADDR_W-1:0] phys_addr;
        logic              perm_rd;
        logic              perm_wr;
        logic              tlb_req;
        logic              addr_err;
        logic [4:0]        exc_code;
    } out_t;

    seg_e              seg;
    route_e            route;
    logic [ADDR_W-1:0] paddr;
    out_t              out_d;

    vseg_classify #(.ADDR_W(ADDR_W)) u_classify (
        .vaddr (vaddr),
        .seg   (seg)
    );

    vseg_grant u_grant (
        .seg       (seg),
        .mode      (mode),
        .err_level (err_level),
        .route     (route)
    );

    vseg_direct #(.ADDR_W(ADDR_W)) u_direct (
        .vaddr (vaddr),
        .seg   (seg),
        .paddr (paddr)
    );

    always_comb begin
        out_d            = '0;
        out_d.seg_id     = seg;
        out_d.phys_valid = (route == ROUTE_DIRECT);
        out_d.tlb_req    = (route == ROUTE_TLB);
        out_d.addr_err   = (route == ROUTE_FAULT);
        out_d.phys_addr  = out_d.phys_valid ? paddr : '0;
        out_d.perm_rd    = out_d.phys_valid;
        out_d.perm_wr    = out_d.phys_valid;
        if (out_d.addr_err) begin
            out_d.exc_code = is_write ? EXC_ADDR_STORE : EXC_ADDR_LOAD;
        end
    end

    assign seg_id     = out_d.seg_id;
    assign phys_valid = out_d.phys_valid;
    assign phys_addr  = out_d.phys_addr;
    assign perm_rd    = out_d.perm_rd;
    assign perm_wr    = out_d.perm_wr;
    assign tlb_req    = out_d.tlb_req;
    assign addr_err   = out_d.addr_err;
    assign exc_code   = out_d.exc_code;

    always_comb begin
        assert_route_onehot_R10: assert ($countones({phys_valid, tlb_req, addr_err}) == 1)
            else $error("route not one-hot");
        assert_erl_identity_R2: assert (!(err_level && !vaddr[ADDR_W-1]) ||
                                        (phys_valid && phys_addr == vaddr))
            else $error("error-level bypass broken");
        assert_kdir_window_R3: assert (!(phys_valid && vaddr[ADDR_W-1]) ||
                                       (mode == PRIV_KERN &&
                                        phys_addr == {3'b000, vaddr[WIN_W-1:0]}))
            else $error("direct kernel window wrong");
        assert_user_top_fault_R6: assert (!(mode[1] && vaddr[ADDR_W-1:WIN_W] == 3'b111) || addr_err)
            else $error("user reached kernel mapped segment");
        assert_exc_code_R7: assert (exc_code == (addr_err ? (is_write ? EXC_ADDR_STORE : EXC_ADDR_LOAD)
                                                          : EXC_NONE))
            else $error("exception code mismatch");
        assert_perm_R8: assert ((perm_rd == phys_valid) && (perm_wr == phys_valid))
            else $error("permission mismatch");
    end

endmodule

// File: tb/test_vseg_decode.sv
module test_vseg_decode;

    logic        clk = 1'b0;
    logic [31:0] vaddr = '0;
    logic [1:0]  mode = '0;
    logic        err_level = 1'b0;
    logic        is_write = 1'b0;
    logic [2:0]  seg_id;
    logic        phys_valid;
    logic [31:0] phys_addr;
    logic        perm_rd;
    logic        perm_wr;
    logic        tlb_req;
    logic        addr_err;
    logic [4:0]  exc_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vseg_decode i_vseg_decode (
        .vaddr      (vaddr),
        .mode       (mode),
        .err_level  (err_level),
        .is_write   (is_write),
        .seg_id     (seg_id),
        .phys_valid (phys_valid),
        .phys_addr  (phys_addr),
        .perm_rd    (perm_rd),
        .perm_wr    (perm_wr),
        .tlb_req    (tlb_req),
        .addr_err   (addr_err),
        .exc_code   (exc_code)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s a=%h m=%0d erl=%0b w=%0b actual=%h expected=%h",
                     req, what, vaddr, mode, err_level, is_write, act, exp);
        end
    endtask

    task automatic apply_and_check(input logic [31:0] a, input logic [1:0] m,
                                   input logic e, input logic w);
        logic        kern, supv, ev, et, ee;
        logic [31:0] ep;
        logic [2:0]  es;
        string       rq;
        @(negedge clk);
        vaddr = a; mode = m; err_level = e; is_write = w;
        kern = (m == 2'd0);
        supv = (m == 2'd1);
        ev = 0; et = 0; ee = 0; ep = 0;
        if (a < 32'h8000_0000) begin
            es = 0;
            if (e) begin ev = 1; ep = a; rq = "R2"; end
            else begin et = 1; rq = "R1"; end
        end else begin
            es = 3'((a >> 29) - 3);
            if (a < 32'hA000_0000) begin
                rq = "R3";
                if (kern) begin ev = 1; ep = a - 32'h8000_0000; end else ee = 1;
            end else if (a < 32'hC000_0000) begin
                rq = "R4";
                if (kern) begin ev = 1; ep = a - 32'hA000_0000; end else ee = 1;
            end else if (a < 32'hE000_0000) begin
                rq = "R5";
                if (kern || supv) et = 1; else ee = 1;
            end else begin
                rq = "R6";
                if (kern) et = 1; else ee = 1;
            end
        end
        if (m == 2'd3) rq = {rq, "/R9"};
        if (a >= 32'h8000_0000) rq = {rq, "/R11"};
        @(posedge clk);
        check(rq, "seg_id", 32'(seg_id), 32'(es));
        check(rq, "phys_valid", 32'(phys_valid), 32'(ev));
        check({rq, "/R10"}, "phys_addr", phys_addr, ep);
        check(rq, "tlb_req", 32'(tlb_req), 32'(et));
        check({rq, "/R7"}, "addr_err", 32'(addr_err), 32'(ee));
        check("R7", "exc_code", 32'(exc_code), ee ? (w ? 32'd5 : 32'd4) : 32'd0);
        check("R8", "perm_rd", 32'(perm_rd), 32'(ev));
        check("R8", "perm_wr", 32'(perm_wr), 32'(ev));
        check("R10", "onehot", 32'(phys_valid) + 32'(tlb_req) + 32'(addr_err), 32'd1);
    endtask

    initial begin
        logic [31:0] lows [4];
        lows[0] = 32'h0000_0000;
        lows[1] = 32'h1FFF_FFFF;
        lows[2] = 32'h0ABC_1235;
        lows[3] = 32'h1000_0000;
        // all-zero inputs at start: kernel, user segment, TLB route (R1)
        apply_and_check(32'h0, 2'd0, 1'b0, 1'b0);
        for (int t = 0; t < 8; t++) begin
            for (int l = 0; l < 4; l++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int e = 0; e < 2; e++) begin
                        for (int w = 0; w < 2; w++) begin
                            apply_and_check((32'(t) << 29) | lows[l], 2'(m), 1'(e), 1'(w));
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule